// File: doc/BRIEF.md
# Programme-Data Readout Target on a Two-Wire Bus

This block is a byte-oriented two-wire (I2C) target. A host microcontroller uses it to fetch the decoded bytes of a programme-delivery data line and to load one 8-bit control register. A fast system clock samples SCL and SDA. The block finds START and STOP conditions and answers one of two address pairs, chosen by a select pin. It pulls SDA low through an open-drain enable and never drives it high.

A read transfer has no register-address phase. Every START rewinds an internal byte pointer to output byte 1. The target then sends bytes MSB first, in a fixed order that remaps and bit-reverses the acquired line bytes. The pointer moves on only when the master acknowledges a byte. The master's ACK is therefore the only back-pressure on the readout stream: a byte is never skipped or repeated unless the master asks for it.

The acquisition side receives two signals. The busy flag tells it that a transfer is in progress, so it can hold off replacing the line snapshot. A one-cycle pulse marks each not-acknowledge from the master. Both bus lines pass through two-flop synchronizers before any decision is made.

Top module: `i2c_readout_target`

## Requirements
- R1: With `addr_sel_i` low the target acknowledges the 8-bit address bytes 0x20 (write) and 0x21 (read). With it high, it acknowledges 0x22 (write) and 0x23 (read). It acknowledges by pulling SDA low during the ninth clock.
- R2: After any other address byte the target gives no ACK. It keeps SDA released for the rest of the transfer, including later data bytes, until the next START, and `busy_o` stays low.
- R3: In a write transfer, the single byte that follows the write address is acknowledged and loaded into `ctrl_o`. `ctrl_o` changes at no other time. Its value does not change what the read path returns.
- R4: At reset `ctrl_o` is 0x00, `busy_o` and `nack_o` are low, and SDA is released.
- R5: Every START, including a repeated START, points the readout at output byte 1. Each byte is sent MSB first.
- R6: A master ACK (SDA low in the ninth clock) advances to the next output byte. A master NACK makes the target release SDA and raise `nack_o` for exactly one system clock. The target then stays silent until the next START.
- R7: Line byte k occupies `line_data_i[8k-1:8k-8]`. Output bytes 1 to 4 come from line bytes 11 to 14. Output byte 5 comes from line byte 5, and output byte 6 comes from line byte 15.
- R8: Bit 0 of a line byte is its first-transmitted bit. It appears as bit 7 of the output byte, and the other bits follow in reversed order.
- R9: Output bytes 7 to 16 read as 0xFF. Up to 16 bytes can be read in one transfer. Beyond byte 16 the pointer holds and 0xFF is returned.
- R10: The target changes its SDA drive only while SCL is low.
- R11: `busy_o` rises when an address matches and falls at the next STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 1 | Picks the address pair (0: 0x20/0x21, 1: 0x22/0x23) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| line_data_i | input | 120 | Acquired line bytes 1..15, byte k at bits 8k-1..8k-8 |
| busy_o | output | 1 | Transfer in progress, from address match to STOP |
| nack_o | output | 1 | One-cycle pulse on a master NACK |
| ctrl_o | output | 8 | Control register |

## Verification
The assertions assume that SCL stays low and high for several system clocks, well beyond the three-cycle synchronizer and edge delay. They also assume that the master changes SDA only while SCL is low, except for START and STOP. The stimulus meets both assumptions: every bus phase lasts ten system clocks, and the master updates SDA only after lowering SCL. The stimulus issues a repeated START only after a NACK, because the target then has SDA released. The line snapshot changes only between transfers.

// File: rtl/i2c_readout_pkg.sv
package i2c_readout_pkg;
  typedef enum logic [2:0] {
    TS_IDLE,   // waiting for START (also: ignoring the bus)
    TS_ADDR,   // shifting in address byte
    TS_AACK,   // driving address ACK
    TS_WDATA,  // shifting in control byte
    TS_WACK,   // driving data ACK
    TS_RDATA,  // shifting out a byte
    TS_RACK,   // sampling master ACK/NACK
    TS_RNEXT   // ACK seen, waiting to load the next byte
  } tgt_state_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BITCNT_W = 4;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned W = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '1;
        else if (s == 0) pipe[s] <= din;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else prev <= pipe[STAGES-1];
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~prev;
  assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/i2c_readout_map.sv
module i2c_readout_map #(
  parameter int unsigned LINE_BYTES = 15,
  parameter int unsigned IDX_W = 4
) (
  input  logic [LINE_BYTES*8-1:0] line_data,
  input  logic [IDX_W-1:0]        idx,
  output logic [7:0]              byte_o
);
  // source line byte (1-based) for output slots 0..5; other slots read all ones
  localparam int unsigned SRC0 = 11;
  localparam int unsigned SRC4 = 5;
  localparam int unsigned SRC5 = 15;

  logic [7:0] raw;

  always_comb begin
    int unsigned slot;
    slot = int'(idx);
    raw  = '1;
    if (slot < 4) raw = line_data[(SRC0 - 1 + slot)*8 +: 8];
    else if (slot == 4) raw = line_data[(SRC4 - 1)*8 +: 8];
    else if (slot == 5) raw = line_data[(SRC5 - 1)*8 +: 8];
  end

  genvar b;
  generate
    for (b = 0; b < 8; b++) begin : g_rev
      assign byte_o[7-b] = raw[b];
    end
  endgenerate
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_readout_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h10,
  parameter int unsigned OUT_BYTES = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_sel,
  input  logic             scl_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             sda_rise,
  input  logic             sda_fall,
  input  logic [7:0]       tx_byte,
  output logic [IDX_W-1:0] idx,
  output logic             sda_oe,
  output logic             busy,
  output logic             nack,
  output logic [7:0]       ctrl
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(OUT_BYTES - 1);
  localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);

  tgt_state_t state;
  logic [BITCNT_W-1:0] cnt;
  logic [7:0] rx, tx;
  logic rd;
  logic start_c, stop_c;
  logic [6:0] my_addr;

  assign start_c = sda_fall & scl_lvl;
  assign stop_c  = sda_rise & scl_lvl;
  assign my_addr = ADDR_BASE | {6'b0, addr_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= TS_IDLE;
      cnt    <= '0;
      rx     <= '0;
      tx     <= '1;
      rd     <= 1'b0;
      idx    <= '0;
      sda_oe <= 1'b0;
      busy   <= 1'b0;
      nack   <= 1'b0;
      ctrl   <= '0;
    end else begin
      nack <= 1'b0;
      if (stop_c) begin
        state  <= TS_IDLE;
        sda_oe <= 1'b0;
        busy   <= 1'b0;
      end else if (start_c) begin
        state  <= TS_ADDR;
        cnt    <= '0;
        idx    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          TS_IDLE: ;
          TS_ADDR: begin
            if (scl_rise) begin
              rx  <= {rx[6:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (rx[7:1] == my_addr) begin
                state  <= TS_AACK;
                sda_oe <= 1'b1;
                busy   <= 1'b1;
                rd     <= rx[0];
              end else begin
                state <= TS_IDLE;
              end
            end
          end
          TS_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd) begin
                tx     <= tx_byte;
                sda_oe <= ~tx_byte[7];
                state  <= TS_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= TS_WDATA;
              end
            end
          end
          TS_WDATA: begin
            if (scl_rise) begin
              rx  <= {rx[6:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              ctrl   <= rx;
              sda_oe <= 1'b1;
              state  <= TS_WACK;
            end
          end
          TS_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= TS_IDLE;
            end
          end
          TS_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= TS_RACK;
              end else begin
                tx     <= {tx[6:0], 1'b1};
                sda_oe <= ~tx[6];
              end
            end
          end
          TS_RACK: begin
            if (scl_rise) begin
              if (!sda_lvl) begin
                state <= TS_RNEXT;
                if (idx != IDX_LAST) idx <= idx + 1'b1;
              end else begin
                nack  <= 1'b1;
                state <= TS_IDLE;
              end
            end
          end
          TS_RNEXT: begin
            if (scl_fall) begin
              tx     <= tx_byte;
              sda_oe <= ~tx_byte[7];
              cnt    <= '0;
              state  <= TS_RDATA;
            end
          end
          default: state <= TS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_readout_target.sv
module i2c_readout_target #(
  parameter int unsigned LINE_BYTES = 15,
  parameter int unsigned OUT_BYTES = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_BASE = 7'h10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    addr_sel_i,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  input  logic [LINE_BYTES*8-1:0] line_data_i,
  output logic                    busy_o,
  output logic                    nack_o,
  output logic [7:0]              ctrl_o
);
  localparam int unsigned IDX_W = $clog2(OUT_BYTES);

  logic [1:0] lvl, rise, fall;
  logic [IDX_W-1:0] idx;
  logic [7:0] tx_byte;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  i2c_readout_map #(.LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)) u_map (
    .line_data(line_data_i), .idx(idx), .byte_o(tx_byte)
  );

  i2c_target_fsm #(.ADDR_BASE(ADDR_BASE), .OUT_BYTES(OUT_BYTES), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel_i),
    .scl_lvl(lvl[1]), .scl_rise(rise[1]), .scl_fall(fall[1]),
    .sda_lvl(lvl[0]), .sda_rise(rise[0]), .sda_fall(fall[0]),
    .tx_byte(tx_byte), .idx(idx), .sda_oe(sda_oe_o),
    .busy(busy_o), .nack(nack_o), .ctrl(ctrl_o)
  );
endmodule

// File: rtl/i2c_readout_chk.sv
module i2c_readout_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       busy_o,
  input logic       nack_o,
  input logic [7:0] ctrl_o
);
  // R10
  sda_drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  // R11
  drive_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> busy_o);

  // R6
  nack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |=> !nack_o);

  // R6
  nack_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |-> busy_o);

  // R3
  ctrl_only_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> busy_o);

  // R4
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (ctrl_o == 8'h00 && !busy_o && !sda_oe_o && !nack_o);
    end
  end
endmodule

bind i2c_readout_target i2c_readout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .busy_o(busy_o), .nack_o(nack_o), .ctrl_o(ctrl_o)
);

// File: tb/i2c_readout_target_test.sv
module i2c_readout_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;          // system clocks per bus phase
  localparam int LB = 15;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [LB*8-1:0] line_data;
  logic sda_oe, busy, nack;
  logic [7:0] ctrl;
  wire sda_line = sda_m & ~sda_oe;

  int compared = 0;
  int mismatched = 0;
  int nack_cnt = 0;
  int oe_hi_changes = 0;
  int cycles = 0;
  logic prev_oe = 1'b0;
  bit chk_en = 1'b0;
  logic exp_busy = 1'b0;
  logic [7:0] exp_ctrl = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_readout_target uut (
    .clk(clk), .rst_n(rst_n), .addr_sel_i(addr_sel), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .line_data_i(line_data), .busy_o(busy), .nack_o(nack), .ctrl_o(ctrl)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference model compared every clock
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      check(busy === exp_busy, "R11 busy", busy, exp_busy);
      check(ctrl === exp_ctrl, "R3 ctrl", ctrl, exp_ctrl);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (nack) nack_cnt++;
    if (rst_n && sda_oe !== prev_oe && scl_m) oe_hi_changes++;
    prev_oe <= sda_oe;
  end

  function automatic [7:0] model_byte(input int n, input logic [LB*8-1:0] ld);
    int src;
    logic [7:0] r;
    if (n <= 4) src = n + 10;
    else if (n == 5) src = 5;
    else if (n == 6) src = 15;
    else src = 0;
    if (src == 0) return 8'hFF;
    for (int i = 0; i < 8; i++) r[7-i] = ld[(src-1)*8 + i];
    return r;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; idle(Q);
    scl_m = 1'b1; idle(Q);
    sda_m = 1'b0; idle(Q);
    scl_m = 1'b0; idle(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; idle(Q);
    scl_m = 1'b1; idle(Q);
    sda_m = 1'b1; idle(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; idle(Q);
    scl_m = 1'b1; idle(Q);
    scl_m = 1'b0; idle(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; idle(Q);
    scl_m = 1'b1; idle(Q);
    b = sda_line;
    scl_m = 1'b0; idle(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit master_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(master_ack ? 1'b0 : 1'b1);
  endtask

  task automatic wr_xfer(input logic [7:0] a, input logic [7:0] d, input bit match);
    logic ack;
    chk_en = 1'b0;
    bus_start();
    send_byte(a, ack);
    check(ack == match, match ? "R1 write address ACK" : "R2 no address ACK", ack, match);
    if (match) exp_busy = 1'b1;
    send_byte(d, ack);
    check(ack == match, match ? "R3 data ACK" : "R2 data ignored", ack, match);
    if (match) exp_ctrl = d;
    chk_en = 1'b1; idle(2); chk_en = 1'b0;
    bus_stop();
    exp_busy = 1'b0;
    chk_en = 1'b1;
    idle(Q);
  endtask

  // reads n bytes, NACKs the last; do_stop=0 leaves the bus for a repeated START
  task automatic rd_xfer(input logic [7:0] a, input int n, input bit match, input bit do_stop,
                         input bit restart);
    logic ack;
    logic [7:0] got;
    int nk;
    chk_en = 1'b0;
    bus_start();
    send_byte(a, ack);
    check(ack == match, match ? (restart ? "R5 repeated START address ACK" : "R1 read address ACK")
                              : "R2 no address ACK", ack, match);
    if (!match) begin
      recv_byte(got, 1'b0);
      check(got == 8'hFF, "R2 SDA released", got, 8'hFF);
    end else begin
      exp_busy = 1'b1;
      chk_en = 1'b1;
      nk = nack_cnt;
      for (int k = 1; k <= n; k++) begin
        recv_byte(got, k < n);
        if (k == 1) check(got == model_byte(k, line_data), "R5 R7 R8 first byte", got, model_byte(k, line_data));
        else if (k <= 6) check(got == model_byte(k, line_data), "R6 R7 R8 byte", got, model_byte(k, line_data));
        else check(got == model_byte(k, line_data), "R9 filler byte", got, model_byte(k, line_data));
      end
      idle(2);
      check(nack_cnt == nk + 1, "R6 nack pulse count", nack_cnt - nk, 1);
      check(sda_oe == 1'b0, "R6 SDA released after NACK", sda_oe, 0);
    end
    chk_en = 1'b0;
    if (do_stop) begin
      bus_stop();
      exp_busy = 1'b0;
      chk_en = 1'b1;
      idle(Q);
    end
  endtask

  initial begin
    logic [7:0] got;
    for (int k = 1; k <= LB; k++) line_data[(k-1)*8 +: 8] = 8'((k * 37 + 1) & 8'hFF);
    line_data[10*8 +: 8] = 8'h01;  // line byte 11
    idle(4);
    // R4 reset state
    check(ctrl == 8'h00, "R4 ctrl reset", ctrl, 0);
    check(busy == 1'b0 && nack == 1'b0, "R4 busy/nack reset", {busy, nack}, 0);
    check(sda_oe == 1'b0, "R4 SDA released", sda_oe, 0);
    rst_n = 1'b1;
    idle(5);
    chk_en = 1'b1;

    // R1 R3 write with select low, low-nibble value
    wr_xfer(8'h20, 8'h0A, 1'b1);

    // R8 single-bit reversal: line byte 11 = 0x01 -> output byte 1 = 0x80
    rd_xfer(8'h21, 16, 1'b1, 1'b1, 1'b0);
    check(model_byte(1, line_data) == 8'h80, "R8 reversal reference", model_byte(1, line_data), 8'h80);

    // R9 read past 16 bytes
    rd_xfer(8'h21, 18, 1'b1, 1'b1, 1'b0);

    // R6 early NACK, then R5 repeated START restarts at byte 1
    rd_xfer(8'h21, 2, 1'b1, 1'b0, 1'b0);
    rd_xfer(8'h21, 3, 1'b1, 1'b1, 1'b1);

    // R2 wrong pair once select goes high
    addr_sel = 1'b1;
    idle(Q);
    wr_xfer(8'h20, 8'h55, 1'b0);
    check(ctrl == 8'h0A, "R2 ctrl untouched", ctrl, 8'h0A);
    rd_xfer(8'h21, 1, 1'b0, 1'b1, 1'b0);

    // R1 select high pair, new line snapshot
    for (int k = 1; k <= LB; k++) line_data[(k-1)*8 +: 8] = 8'((k * 13) ^ 8'hA5);
    idle(Q);
    wr_xfer(8'h22, 8'h05, 1'b1);
    rd_xfer(8'h23, 7, 1'b1, 1'b1, 1'b0);
    wr_xfer(8'h22, 8'h0F, 1'b1);
    rd_xfer(8'h23, 6, 1'b1, 1'b1, 1'b0);

    // R10 drive changes only while SCL low
    check(oe_hi_changes == 0, "R10 SDA change with SCL high", oe_hi_changes, 0);

    chk_en = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    chk_en = 1'b0;
    check(1'b0, "watchdog", cycles, WATCHDOG);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule